// File: doc/BRIEF.md
# Fault Escalation Controller

This block carries an interrupt or exception vector to its handler through a descriptor table defined by a base address and a byte limit. When a vector request is accepted, the controller checks whether that vector's 8-byte descriptor lies inside the table. If it does, the controller fetches the descriptor from memory. If it does not, or if the fetch fails, the controller does not give up. It retries with the general protection vector (13), and after that with the double fault vector (8).

If even the double fault cannot be delivered, the controller enters shutdown. It emits a one-cycle shutdown bus cycle indication and holds a system reset request until the external reset arrives. A successful delivery at any depth produces a one-cycle report carrying the vector that was finally delivered and the address of its descriptor.

The memory side is a simple level handshake. The fetch request and its address are held until memory answers with done, together with an error flag.

Top module: `fault_escalator`

## Requirements
- R1: After reset, the delivery strobe, fetch request, shutdown indication and reset request are all low, and the controller is idle.
- R2: A request accepted in idle makes the controller present a fetch request at address base + 8 × vector, provided the vector is in range. The request and address stay steady until memory signals done.
- R3: A fetch that completes without error produces a delivery strobe one cycle after the completing edge, high for exactly one cycle. The strobe carries the delivered vector and its descriptor address.
- R4: Vector n is in range only when 8n + 7 ≤ limit. An out-of-range vector issues no fetch, and the controller escalates to vector 13.
- R5: A fetch that completes with the error flag set escalates exactly as an out-of-range vector does.
- R6: A failure while delivering vector 13 escalates to vector 8.
- R7: A failure while delivering vector 8 enters shutdown. The shutdown indication is high for exactly one cycle, and the reset request rises with it.
- R8: Shutdown is sticky. The reset request stays high, and new requests produce neither a fetch nor a delivery until reset.
- R9: A request that arrives while a delivery or escalation is in progress is ignored.
- R10: The limit check is exact at the boundary. With limit = 8n + 7 vector n is in range, and with limit = 8n + 6 it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_i | input | ADDR_W | Descriptor table base address |
| tbl_limit_i | input | LIM_W | Descriptor table byte limit |
| req_valid_i | input | 1 | Vector request strobe, honoured only in idle |
| req_vec_i | input | VEC_W | Requested vector number |
| fetch_req_o | output | 1 | Descriptor fetch request, held until done |
| fetch_addr_o | output | ADDR_W | Descriptor fetch address |
| fetch_done_i | input | 1 | Memory completed the current fetch |
| fetch_err_i | input | 1 | The completing fetch failed |
| dlv_valid_o | output | 1 | One-cycle delivery strobe |
| dlv_vec_o | output | VEC_W | Vector actually delivered |
| dlv_addr_o | output | ADDR_W | Descriptor address of the delivered vector |
| shutdown_cycle_o | output | 1 | One-cycle shutdown bus cycle indication |
| sys_reset_req_o | output | 1 | System reset request, held during shutdown |

## Verification
A wrong escalation depth shows up at the ports within one cycle. The fetch address jumps to the wrong fallback descriptor, or the delivered vector differs from the one expected. A lost sticky state shows as the reset request dropping, or a fetch reappearing after shutdown, within one cycle of the corruption. An off-by-one in the range check changes the outcome only at the exact limit boundary, so those limits are driven on purpose. Extra or missing strobes show up on the cycle after the completing fetch.

// File: rtl/fault_escalator_pkg.sv
package fault_escalator_pkg;

    typedef enum logic [2:0] {
        ESC_IDLE     = 3'd0,
        ESC_DELIVER  = 3'd1,
        ESC_GP       = 3'd2,
        ESC_DF       = 3'd3,
        ESC_SHUTDOWN = 3'd4
    } esc_state_e;

    localparam int DEFAULT_GP_VEC = 13;
    localparam int DEFAULT_DF_VEC = 8;

endpackage

// File: rtl/desc_locator.sv
module desc_locator #(
    parameter int ADDR_W     = 32,
    parameter int LIM_W      = 16,
    parameter int VEC_W      = 8,
    parameter int DESC_SHIFT = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              in_range_o
);
    localparam int SPAN_W = VEC_W + DESC_SHIFT;
    localparam int CMP_W  = ((SPAN_W > LIM_W) ? SPAN_W : LIM_W) + 1;
    localparam logic [CMP_W-1:0] TAIL = CMP_W'((1 << DESC_SHIFT) - 1);

    logic [CMP_W-1:0] first_byte;
    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] limit_ext;

    always_comb begin
        first_byte = CMP_W'(vec_i) << DESC_SHIFT;
        last_byte  = first_byte | TAIL;
        limit_ext  = CMP_W'(limit_i);
        in_range_o = (last_byte <= limit_ext);
        addr_o     = base_i + ADDR_W'(first_byte);
    end
endmodule

// File: rtl/esc_sequencer.sv
module esc_sequencer
    import fault_escalator_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8,
    parameter int GP_VEC = DEFAULT_GP_VEC,
    parameter int DF_VEC = DEFAULT_DF_VEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [VEC_W-1:0]  req_vec_i,
    input  logic              in_range_i,
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic              fetch_done_i,
    input  logic              fetch_err_i,
    output logic [VEC_W-1:0]  cur_vec_o,
    output logic              fetch_req_o,
    output logic              dlv_valid_o,
    output logic [VEC_W-1:0]  dlv_vec_o,
    output logic [ADDR_W-1:0] dlv_addr_o,
    output logic              shutdown_cycle_o,
    output logic              sys_reset_req_o
);
    localparam logic [VEC_W-1:0] GP_V = VEC_W'(GP_VEC);
    localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

    typedef struct packed {
        esc_state_e         st;
        logic [VEC_W-1:0]   vec;
        logic               dlv_v;
        logic [VEC_W-1:0]   dlv_vec;
        logic [ADDR_W-1:0]  dlv_addr;
        logic               sd_pulse;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ESC_IDLE, vec: '0, dlv_v: 1'b0, dlv_vec: '0,
        dlv_addr: '0, sd_pulse: 1'b0
    };

    seq_regs_t regs_q, regs_d;
    logic      escalate;
    logic      deliver;
    logic      fetch_req;

    always_comb begin
        regs_d          = regs_q;
        regs_d.dlv_v    = 1'b0;
        regs_d.sd_pulse = 1'b0;
        fetch_req       = 1'b0;
        escalate        = 1'b0;
        deliver         = 1'b0;

        case (regs_q.st)
            ESC_IDLE: begin
                if (req_valid_i) begin
                    regs_d.st  = ESC_DELIVER;
                    regs_d.vec = req_vec_i;
                end
            end
            ESC_DELIVER, ESC_GP, ESC_DF: begin
                if (!in_range_i) begin
                    escalate = 1'b1;
                end else begin
                    fetch_req = 1'b1;
                    if (fetch_done_i) begin
                        if (fetch_err_i) escalate = 1'b1;
                        else             deliver  = 1'b1;
                    end
                end
            end
            ESC_SHUTDOWN: begin
                regs_d.st = ESC_SHUTDOWN;
            end
            default: begin
                regs_d.st = ESC_IDLE;
            end
        endcase

        if (deliver) begin
            regs_d.dlv_v    = 1'b1;
            regs_d.dlv_vec  = regs_q.vec;
            regs_d.dlv_addr = desc_addr_i;
            regs_d.st       = ESC_IDLE;
        end

        if (escalate) begin
            case (regs_q.st)
                ESC_DELIVER: begin
                    regs_d.st  = ESC_GP;
                    regs_d.vec = GP_V;
                end
                ESC_GP: begin
                    regs_d.st  = ESC_DF;
                    regs_d.vec = DF_V;
                end
                ESC_DF: begin
                    regs_d.st       = ESC_SHUTDOWN;
                    regs_d.sd_pulse = 1'b1;
                end
                default: begin
                    regs_d.st = ESC_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    assign cur_vec_o        = regs_q.vec;
    assign fetch_req_o      = fetch_req;
    assign dlv_valid_o      = regs_q.dlv_v;
    assign dlv_vec_o        = regs_q.dlv_vec;
    assign dlv_addr_o       = regs_q.dlv_addr;
    assign shutdown_cycle_o = regs_q.sd_pulse;
    assign sys_reset_req_o  = (regs_q.st == ESC_SHUTDOWN);
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
    import fault_escalator_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIM_W      = 16,
    parameter int VEC_W      = 8,
    parameter int DESC_SHIFT = 3,
    parameter int GP_VEC     = DEFAULT_GP_VEC,
    parameter int DF_VEC     = DEFAULT_DF_VEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [LIM_W-1:0]  tbl_limit_i,
    input  logic              req_valid_i,
    input  logic [VEC_W-1:0]  req_vec_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_done_i,
    input  logic              fetch_err_i,
    output logic              dlv_valid_o,
    output logic [VEC_W-1:0]  dlv_vec_o,
    output logic [ADDR_W-1:0] dlv_addr_o,
    output logic              shutdown_cycle_o,
    output logic              sys_reset_req_o
);
    logic [VEC_W-1:0]  cur_vec;
    logic [ADDR_W-1:0] desc_addr;
    logic              in_range;

    desc_locator #(
        .ADDR_W(ADDR_W), .LIM_W(LIM_W), .VEC_W(VEC_W), .DESC_SHIFT(DESC_SHIFT)
    ) u_locator (
        .base_i    (tbl_base_i),
        .limit_i   (tbl_limit_i),
        .vec_i     (cur_vec),
        .addr_o    (desc_addr),
        .in_range_o(in_range)
    );

    esc_sequencer #(
        .ADDR_W(ADDR_W), .VEC_W(VEC_W), .GP_VEC(GP_VEC), .DF_VEC(DF_VEC)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid_i),
        .req_vec_i       (req_vec_i),
        .in_range_i      (in_range),
        .desc_addr_i     (desc_addr),
        .fetch_done_i    (fetch_done_i),
        .fetch_err_i     (fetch_err_i),
        .cur_vec_o       (cur_vec),
        .fetch_req_o     (fetch_req_o),
        .dlv_valid_o     (dlv_valid_o),
        .dlv_vec_o       (dlv_vec_o),
        .dlv_addr_o      (dlv_addr_o),
        .shutdown_cycle_o(shutdown_cycle_o),
        .sys_reset_req_o (sys_reset_req_o)
    );

    assign fetch_addr_o = desc_addr;
endmodule

// File: rtl/fault_escalator_chk.sv
module fault_escalator_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req_o,
    input logic              fetch_done_i,
    input logic              fetch_err_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [ADDR_W-1:0] dlv_addr_o,
    input logic              dlv_valid_o,
    input logic              shutdown_cycle_o,
    input logic              sys_reset_req_o
);
    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && !fetch_done_i |=> fetch_req_o && $stable(fetch_addr_o));

    // R3
    dlv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> $past(fetch_req_o && fetch_done_i && !fetch_err_i)
                        && (dlv_addr_o == $past(fetch_addr_o)));

    // R3
    dlv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |=> !dlv_valid_o);

    // R7
    sd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_cycle_o |=> !shutdown_cycle_o && sys_reset_req_o);

    // R7
    sd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_req_o) |-> shutdown_cycle_o);

    // R8
    sd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req_o |=> sys_reset_req_o);

    // R8
    sd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req_o |-> !fetch_req_o && !dlv_valid_o);
endmodule

bind fault_escalator fault_escalator_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_req_o     (fetch_req_o),
    .fetch_done_i    (fetch_done_i),
    .fetch_err_i     (fetch_err_i),
    .fetch_addr_o    (fetch_addr_o),
    .dlv_addr_o      (dlv_addr_o),
    .dlv_valid_o     (dlv_valid_o),
    .shutdown_cycle_o(shutdown_cycle_o),
    .sys_reset_req_o (sys_reset_req_o)
);

// File: tb/fault_escalator_bench.sv
module fault_escalator_bench;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base_i = BASE;
    logic [15:0] tbl_limit_i = 16'h07FF;
    logic        req_valid_i = 1'b0;
    logic [7:0]  req_vec_i = '0;
    logic        fetch_req_o;
    logic [31:0] fetch_addr_o;
    logic        fetch_done_i;
    logic        fetch_err_i;
    logic        dlv_valid_o;
    logic [7:0]  dlv_vec_o;
    logic [31:0] dlv_addr_o;
    logic        shutdown_cycle_o;
    logic        sys_reset_req_o;

    logic        mem_en = 1'b1;
    logic [3:0]  err_mask = '0;
    logic        idx_clr = 1'b0;
    logic [1:0]  fetch_idx;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    // memory model: answers immediately when enabled, error chosen by fetch order
    assign fetch_done_i = fetch_req_o & mem_en;
    assign fetch_err_i  = err_mask[fetch_idx];

    always_ff @(posedge clk) begin
        if (idx_clr)                         fetch_idx <= '0;
        else if (fetch_req_o && fetch_done_i) fetch_idx <= fetch_idx + 2'd1;
    end

    fault_escalator u_fault_escalator (
        .clk(clk), .rst_n(rst_n),
        .tbl_base_i(tbl_base_i), .tbl_limit_i(tbl_limit_i),
        .req_valid_i(req_valid_i), .req_vec_i(req_vec_i),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_done_i(fetch_done_i), .fetch_err_i(fetch_err_i),
        .dlv_valid_o(dlv_valid_o), .dlv_vec_o(dlv_vec_o), .dlv_addr_o(dlv_addr_o),
        .shutdown_cycle_o(shutdown_cycle_o), .sys_reset_req_o(sys_reset_req_o)
    );

    typedef struct packed {
        logic [15:0] lim;
        logic [7:0]  vec;
        logic [3:0]  mask;
        logic        shut;
        logic [7:0]  evec;
    } case_t;

    localparam int NCASE = 12;
    localparam case_t TBL [NCASE] = '{
        '{16'h07FF, 8'd32,  4'b0000, 1'b0, 8'd32},  // R2 R3 plain delivery
        '{16'h00FF, 8'd40,  4'b0000, 1'b0, 8'd13},  // R4 out of range -> 13
        '{16'h00FF, 8'd5,   4'b0001, 1'b0, 8'd13},  // R5 fetch error -> 13
        '{16'h00FF, 8'd5,   4'b0011, 1'b0, 8'd8},   // R6 13 fails -> 8
        '{16'h00FF, 8'd5,   4'b0111, 1'b0, 8'd0},   // R7 all fail -> shutdown
        '{16'h0047, 8'd20,  4'b0000, 1'b0, 8'd8},   // R10 limit 71: 8 in, 13 out
        '{16'h0046, 8'd8,   4'b0000, 1'b1, 8'd0},   // R10 limit 70: 8 out
        '{16'h006F, 8'd13,  4'b0000, 1'b0, 8'd13},  // R10 vector 13 at boundary
        '{16'h006F, 8'd14,  4'b0000, 1'b0, 8'd13},  // R4 14 just out
        '{16'h0000, 8'd0,   4'b0000, 1'b1, 8'd0},   // R7 empty table
        '{16'h0007, 8'd0,   4'b0000, 1'b0, 8'd0},   // R10 one descriptor
        '{16'h07FF, 8'd255, 4'b0000, 1'b0, 8'd255}  // R2 top vector
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idx_clr = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idx_clr = 1'b0;
    endtask

    task automatic send_req(input logic [7:0] v);
        @(negedge clk);
        idx_clr = 1'b1;
        req_vec_i = v;
        req_valid_i = 1'b1;
        @(negedge clk);
        idx_clr = 1'b0;
        req_valid_i = 1'b0;
    endtask

    task automatic wait_outcome(output logic got_dlv, output logic got_sd);
        got_dlv = 1'b0;
        got_sd = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (dlv_valid_o) begin got_dlv = 1'b1; break; end
            if (shutdown_cycle_o) begin got_sd = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        logic got_dlv, got_sd;
        do_reset();

        // R1 reset state
        check(!dlv_valid_o && !fetch_req_o && !shutdown_cycle_o && !sys_reset_req_o,
              "R1 reset outputs",
              {28'd0, dlv_valid_o, fetch_req_o, shutdown_cycle_o, sys_reset_req_o}, 32'd0);

        // vector table walk
        for (int i = 0; i < NCASE; i++) begin
            tbl_limit_i = TBL[i].lim;
            err_mask = TBL[i].mask;
            send_req(TBL[i].vec);
            wait_outcome(got_dlv, got_sd);
            if (TBL[i].shut || TBL[i].mask == 4'b0111) begin
                check(got_sd && sys_reset_req_o, "R7 shutdown entered", {31'd0, got_sd}, 32'd1);
                @(negedge clk);
                check(!shutdown_cycle_o && sys_reset_req_o, "R7 pulse one cycle, reset held",
                      {30'd0, shutdown_cycle_o, sys_reset_req_o}, 32'd1);
                do_reset();
            end else begin
                check(got_dlv, "R3 delivery seen", {31'd0, got_dlv}, 32'd1);
                check(dlv_vec_o == TBL[i].evec, "R4/R5/R6 delivered vector",
                      {24'd0, dlv_vec_o}, {24'd0, TBL[i].evec});
                check(dlv_addr_o == BASE + 32'(TBL[i].evec) * 8, "R2 descriptor address",
                      dlv_addr_o, BASE + 32'(TBL[i].evec) * 8);
                @(negedge clk);
                check(!dlv_valid_o, "R3 strobe one cycle", {31'd0, dlv_valid_o}, 32'd0);
            end
        end
        err_mask = '0;

        // R2 stalled memory: request and address held
        tbl_limit_i = 16'h00FF;
        mem_en = 1'b0;
        send_req(8'd3);
        for (int k = 0; k < 3; k++) begin
            check(fetch_req_o && fetch_addr_o == BASE + 32'd24 && !dlv_valid_o,
                  "R2 fetch held during stall", fetch_addr_o, BASE + 32'd24);
            if (k == 1) begin
                // R9 request while busy must be ignored
                req_vec_i = 8'd7;
                req_valid_i = 1'b1;
            end
            @(negedge clk);
            req_valid_i = 1'b0;
        end
        mem_en = 1'b1;
        @(negedge clk);
        check(dlv_valid_o && dlv_vec_o == 8'd3, "R3 delivery after stall",
              {24'd0, dlv_vec_o}, 32'd3);
        got_dlv = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (dlv_valid_o || fetch_req_o) got_dlv = 1'b1;
        end
        check(!got_dlv, "R9 busy request ignored", {31'd0, got_dlv}, 32'd0);

        // R8 sticky shutdown
        tbl_limit_i = 16'h0000;
        send_req(8'd0);
        wait_outcome(got_dlv, got_sd);
        check(got_sd, "R8 shutdown reached", {31'd0, got_sd}, 32'd1);
        tbl_limit_i = 16'h07FF;
        send_req(8'd1);
        got_dlv = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (dlv_valid_o || fetch_req_o || !sys_reset_req_o) got_dlv = 1'b1;
            @(negedge clk);
        end
        check(!got_dlv, "R8 requests ignored in shutdown", {31'd0, got_dlv}, 32'd0);
        do_reset();
        check(!sys_reset_req_o, "R1 reset clears shutdown", {31'd0, sys_reset_req_o}, 32'd0);
        send_req(8'd1);
        wait_outcome(got_dlv, got_sd);
        check(got_dlv && dlv_vec_o == 8'd1, "R8 service resumes after reset",
              {24'd0, dlv_vec_o}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule